// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block is the receive half of a configurable asynchronous serial port. It uses a 16x oversampling tick to watch a serial line. It finds the start of each character and samples every later bit at the middle of its bit time. It collects 5 to 8 data bits, least significant first, and then checks an optional parity bit and one or two stop bits. The finished character goes into a single holding register. The host takes it from there with a read pulse.

Alongside the character the block reports data-ready, parity error, framing error, overrun and break. The character format comes from static configuration inputs: word length, receive parity mode and stop-bit select. A receiver enable and a loopback source select complete the inputs. A loopback source lets the transmit path of the same port feed the receiver directly. Bus decoding, the transmitter and interrupt logic belong to other blocks.

Top module: `serial_rx_unit`

## Requirements
- R1: A character begins on a high-to-low transition of the selected line, after that line passes a two-stage synchroniser. Eight ticks after the edge the line is sampled again. If it is high, the receiver returns to idle and loads nothing.
- R2: Data bits are sampled every 16 ticks after the start-bit midpoint. `wordLenSel` 00/01/10/11 selects 5/6/7/8 bits. The first bit received lands in `rxData[0]`, and unused high bits of `rxData` read 0.
- R3: `parityCtl` sets the receive check: 000 and 011 even, 001 and 010 odd, 100 and 101 no check with a parity bit still expected, 110 and 111 no check and no parity bit in the frame.
- R4: `parityErr` is 1 when the data bits plus the parity bit have an odd count of ones in even mode, or an even count in odd mode. It is always 0 when checking is off. In odd mode, 0x6E with parity bit 1 is an error.
- R5: `framingErr` is 1 when any checked stop bit samples 0. Two stop bits are checked when `stopSel`=1 and the word is 6 to 8 bits. Only one is checked when the word is 5 bits or `stopSel`=0.
- R6: `breakDet` is 1 when every data, parity and stop sample of the character was 0. Such a character also reports a framing error and data 0.
- R7: If a character completes while `dataReady`=1 and no read pulse is present, `overrunErr` becomes 1 and `rxData` and its flags keep the earlier character.
- R8: A one-cycle `readStrobe` clears `dataReady`, `overrunErr`, `parityErr`, `framingErr` and `breakDet`. If a character completes in the same cycle, the new character is loaded instead.
- R9: While `rxEnable`=0 the receiver stays idle, ignores the line and loads no character.
- R10: `loopSel`=1 takes the line from `loopIn` and ignores `serialIn`. `loopSel`=0 takes the line from `serialIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| serialIn | input | 1 | External serial line, idle high |
| loopIn | input | 1 | Internal loopback line from the transmitter |
| loopSel | input | 1 | 1 selects loopIn as the receive source |
| rxEnable | input | 1 | 1 allows reception |
| wordLenSel | input | 2 | Data bit count code (5 + value) |
| parityCtl | input | 3 | Receive parity mode code |
| stopSel | input | 1 | Stop bit select |
| readStrobe | input | 1 | Host read of the holding register |
| rxData | output | 8 | Held character, right justified and zero filled |
| dataReady | output | 1 | Holding register holds an unread character |
| parityErr | output | 1 | Held character failed its parity check |
| framingErr | output | 1 | Held character had a low stop bit |
| overrunErr | output | 1 | A character was lost while the register was full |
| breakDet | output | 1 | Held character was an all-zero break |

## Verification
Most internal faults show up at the ports within one character time. A bit index or tick counter that is off by one moves data bits to wrong positions or picks up the parity or stop level as data, so `rxData` is wrong on the very next character. A state machine that takes the wrong branch for the parity bit or the second stop bit shifts every later sample by a whole bit period, which raises a false `framingErr` or `parityErr` on that same character. Faults in the holding logic, such as data being replaced on overrun or flags that survive a read, are visible in the cycle after the load or read pulse.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int RX_MAX_BITS = 8;
  localparam int RX_MIN_BITS = 5;
  localparam int RX_IDX_W    = $clog2(RX_MAX_BITS);

  typedef enum logic [1:0] {
    RXP_EVEN   = 2'd0,
    RXP_ODD    = 2'd1,
    RXP_SKIP   = 2'd2,   // parity bit present, not checked
    RXP_ABSENT = 2'd3    // no parity bit in the frame
  } rx_par_e;

  // Strobes from the frame sequencer to the datapath
  typedef struct packed {
    logic                startFrame;
    logic                sampleData;
    logic                sampleParity;
    logic                sampleStop;
    logic                loadChar;
    logic [RX_IDX_W-1:0] bitIdx;
  } rx_strobe_t;

  function automatic rx_par_e decodeRxParity(input logic [2:0] ctl);
    rx_par_e mode;
    case (ctl)
      3'b000, 3'b011: mode = RXP_EVEN;
      3'b001, 3'b010: mode = RXP_ODD;
      3'b100, 3'b101: mode = RXP_SKIP;
      default:        mode = RXP_ABSENT;
    endcase
    return mode;
  endfunction

endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       lineS,
  input  logic       fallEdge,
  input  logic       rxEnable,
  input  logic [1:0] wordLenSel,
  input  rx_par_e    parMode,
  input  logic       stopSel,
  output rx_strobe_t strb
);

  localparam int CNT_W    = $clog2(OVERSAMPLE);
  localparam int MID_TICK = OVERSAMPLE / 2 - 1;
  localparam int END_TICK = OVERSAMPLE - 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP1, ST_STOP2, ST_LOAD
  } rx_state_e;

  rx_state_e           state, stateNxt;
  logic [CNT_W-1:0]    tickCnt, cntNxt;
  logic [RX_IDX_W-1:0] bitIdx, idxNxt;
  logic                atMid, atEnd, lastBit, twoStops;

  assign atMid    = tick16 && (tickCnt == CNT_W'(MID_TICK));
  assign atEnd    = tick16 && (tickCnt == CNT_W'(END_TICK));
  assign lastBit  = (bitIdx == RX_IDX_W'(wordLenSel) + RX_IDX_W'(RX_MIN_BITS - 1));
  assign twoStops = stopSel && (wordLenSel != 2'b00);

  always_comb begin
    stateNxt    = state;
    cntNxt      = tickCnt;
    idxNxt      = bitIdx;
    strb        = '0;
    strb.bitIdx = bitIdx;

    if (tick16 && state != ST_IDLE && state != ST_LOAD)
      cntNxt = atEnd ? '0 : tickCnt + CNT_W'(1);

    case (state)
      ST_IDLE: begin
        cntNxt = '0;
        if (fallEdge) begin
          stateNxt        = ST_START;
          strb.startFrame = 1'b1;
        end
      end
      ST_START: begin
        if (atMid) begin
          cntNxt   = '0;
          idxNxt   = '0;
          stateNxt = lineS ? ST_IDLE : ST_DATA;
        end
      end
      ST_DATA: begin
        if (atEnd) begin
          strb.sampleData = 1'b1;
          if (lastBit) begin
            idxNxt   = '0;
            stateNxt = (parMode == RXP_ABSENT) ? ST_STOP1 : ST_PARITY;
          end else begin
            idxNxt = bitIdx + RX_IDX_W'(1);
          end
        end
      end
      ST_PARITY: begin
        if (atEnd) begin
          strb.sampleParity = 1'b1;
          stateNxt          = ST_STOP1;
        end
      end
      ST_STOP1: begin
        if (atEnd) begin
          strb.sampleStop = 1'b1;
          stateNxt        = twoStops ? ST_STOP2 : ST_LOAD;
        end
      end
      ST_STOP2: begin
        if (atEnd) begin
          strb.sampleStop = 1'b1;
          stateNxt        = ST_LOAD;
        end
      end
      ST_LOAD: begin
        strb.loadChar = 1'b1;
        stateNxt      = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase

    if (!rxEnable) begin
      stateNxt = ST_IDLE;
      cntNxt   = '0;
      idxNxt   = '0;
      strb     = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      state   <= stateNxt;
      tickCnt <= cntNxt;
      bitIdx  <= idxNxt;
    end
  end

endmodule

// File: rtl/serial_rx_datapath.sv
module serial_rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   serialIn,
  input  logic                   loopIn,
  input  logic                   loopSel,
  input  rx_par_e                parMode,
  input  rx_strobe_t             strb,
  input  logic                   readStrobe,
  output logic                   lineS,
  output logic                   fallEdge,
  output logic [RX_MAX_BITS-1:0] rxData,
  output logic                   dataReady,
  output logic                   parityErr,
  output logic                   framingErr,
  output logic                   overrunErr,
  output logic                   breakDet
);

  logic                   srcLine, prevLine;
  logic [SYNC_STAGES-1:0] syncQ;
  logic [RX_MAX_BITS-1:0] asmData;
  logic                   parAcc, allZero, stopBad, parFail, accept, anySample;

  assign srcLine = loopSel ? loopIn : serialIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '1;
      prevLine <= 1'b1;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], srcLine};
      prevLine <= syncQ[SYNC_STAGES-1];
    end
  end

  assign lineS    = syncQ[SYNC_STAGES-1];
  assign fallEdge = prevLine && !lineS;

  assign anySample = strb.sampleData || strb.sampleParity || strb.sampleStop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asmData <= '0;
      parAcc  <= 1'b0;
      allZero <= 1'b1;
      stopBad <= 1'b0;
    end else if (strb.startFrame) begin
      asmData <= '0;
      parAcc  <= 1'b0;
      allZero <= 1'b1;
      stopBad <= 1'b0;
    end else begin
      if (strb.sampleData)
        asmData[strb.bitIdx] <= lineS;
      if (strb.sampleData || strb.sampleParity)
        parAcc <= parAcc ^ lineS;
      if (anySample && lineS)
        allZero <= 1'b0;
      if (strb.sampleStop && !lineS)
        stopBad <= 1'b1;
    end
  end

  always_comb begin
    case (parMode)
      RXP_EVEN: parFail = parAcc;
      RXP_ODD:  parFail = !parAcc;
      default:  parFail = 1'b0;
    endcase
  end

  assign accept = strb.loadChar && (!dataReady || readStrobe);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      dataReady  <= 1'b0;
      parityErr  <= 1'b0;
      framingErr <= 1'b0;
      breakDet   <= 1'b0;
      overrunErr <= 1'b0;
    end else if (accept) begin
      rxData     <= asmData;
      dataReady  <= 1'b1;
      parityErr  <= parFail;
      framingErr <= stopBad;
      breakDet   <= allZero;
      overrunErr <= 1'b0;
    end else if (strb.loadChar) begin
      overrunErr <= 1'b1;
    end else if (readStrobe) begin
      dataReady  <= 1'b0;
      parityErr  <= 1'b0;
      framingErr <= 1'b0;
      breakDet   <= 1'b0;
      overrunErr <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       serialIn,
  input  logic       loopIn,
  input  logic       loopSel,
  input  logic       rxEnable,
  input  logic [1:0] wordLenSel,
  input  logic [2:0] parityCtl,
  input  logic       stopSel,
  input  logic       readStrobe,
  output logic [7:0] rxData,
  output logic       dataReady,
  output logic       parityErr,
  output logic       framingErr,
  output logic       overrunErr,
  output logic       breakDet
);

  rx_par_e    parMode;
  rx_strobe_t strb;
  logic       lineS, fallEdge, loadPulse;

  assign parMode   = decodeRxParity(parityCtl);
  assign loadPulse = strb.loadChar;

  serial_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .tick16     (tick16),
    .lineS      (lineS),
    .fallEdge   (fallEdge),
    .rxEnable   (rxEnable),
    .wordLenSel (wordLenSel),
    .parMode    (parMode),
    .stopSel    (stopSel),
    .strb       (strb)
  );

  serial_rx_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .serialIn   (serialIn),
    .loopIn     (loopIn),
    .loopSel    (loopSel),
    .parMode    (parMode),
    .strb       (strb),
    .readStrobe (readStrobe),
    .lineS      (lineS),
    .fallEdge   (fallEdge),
    .rxData     (rxData),
    .dataReady  (dataReady),
    .parityErr  (parityErr),
    .framingErr (framingErr),
    .overrunErr (overrunErr),
    .breakDet   (breakDet)
  );

endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rxEnable,
  input logic       readStrobe,
  input logic [2:0] parityCtl,
  input logic       loadPulse,
  input logic [7:0] rxData,
  input logic       dataReady,
  input logic       parityErr,
  input logic       framingErr,
  input logic       overrunErr,
  input logic       breakDet
);

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe && !loadPulse |=> !dataReady && !overrunErr && !parityErr && !framingErr && !breakDet); // R8

  AST_FLAGS_NEED_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr || framingErr || breakDet || overrunErr) |-> dataReady); // R8

  AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    dataReady && !readStrobe && loadPulse |=> overrunErr && (rxData == $past(rxData))); // R7

  AST_HELD_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    dataReady && !readStrobe |=> $stable(rxData)); // R7

  AST_NO_PE_UNCHECKED: assert property (@(posedge clk) disable iff (!rstN)
    loadPulse && parityCtl[2] && (!dataReady || readStrobe) |=> !parityErr); // R4

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !$rose(dataReady)); // R9

  AST_BREAK_FRAMES: assert property (@(posedge clk) disable iff (!rstN)
    breakDet |-> framingErr && (rxData == 8'h00)); // R6

endmodule

bind serial_rx_unit serial_rx_checker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .rxEnable   (rxEnable),
  .readStrobe (readStrobe),
  .parityCtl  (parityCtl),
  .loadPulse  (loadPulse),
  .rxData     (rxData),
  .dataReady  (dataReady),
  .parityErr  (parityErr),
  .framingErr (framingErr),
  .overrunErr (overrunErr),
  .breakDet   (breakDet)
);

// File: tb/serial_rx_unit_tb.sv
module serial_rx_unit_tb_top;

  localparam int BIT_CLKS = 64;   // 16 ticks of 4 clocks

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic [1:0] tickDiv = 2'd0;
  logic       serialLine = 1'b1;
  logic       loopLine = 1'b1;
  logic       loopSel = 1'b0;
  logic       rxEnable = 1'b1;
  logic [1:0] wordLenSel = 2'b11;
  logic [2:0] parityCtl = 3'b000;
  logic       stopSel = 1'b0;
  logic       readStrobe = 1'b0;
  logic [7:0] rxData;
  logic       dataReady, parityErr, framingErr, overrunErr, breakDet;

  int  testCnt = 0;
  int  failCnt = 0;
  bit  doneFlag = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tickDiv <= tickDiv + 2'd1;
    tick16  <= (tickDiv == 2'd3);
  end

  serial_rx_unit dut_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .serialIn(serialLine),
    .loopIn(loopLine), .loopSel(loopSel), .rxEnable(rxEnable),
    .wordLenSel(wordLenSel), .parityCtl(parityCtl), .stopSel(stopSel),
    .readStrobe(readStrobe), .rxData(rxData), .dataReady(dataReady),
    .parityErr(parityErr), .framingErr(framingErr),
    .overrunErr(overrunErr), .breakDet(breakDet)
  );

  // {wordLen[2], parity[3], stopSel, data[8], flipParity, badStop[2], break}
  localparam logic [17:0] VECS [0:12] = '{
    {2'b11, 3'b000, 1'b0, 8'hA5, 1'b0, 2'd0, 1'b0},
    {2'b00, 3'b001, 1'b0, 8'hFF, 1'b0, 2'd0, 1'b0},
    {2'b01, 3'b010, 1'b0, 8'h2A, 1'b0, 2'd0, 1'b0},
    {2'b10, 3'b011, 1'b0, 8'h7F, 1'b1, 2'd0, 1'b0},
    {2'b11, 3'b001, 1'b0, 8'h6E, 1'b1, 2'd0, 1'b0},
    {2'b11, 3'b100, 1'b0, 8'h3C, 1'b1, 2'd0, 1'b0},
    {2'b11, 3'b110, 1'b0, 8'hC3, 1'b0, 2'd0, 1'b0},
    {2'b11, 3'b111, 1'b1, 8'h81, 1'b0, 2'd2, 1'b0},
    {2'b00, 3'b000, 1'b1, 8'h0A, 1'b0, 2'd0, 1'b0},
    {2'b11, 3'b000, 1'b0, 8'h00, 1'b0, 2'd0, 1'b1},
    {2'b01, 3'b000, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0},
    {2'b11, 3'b000, 1'b0, 8'h3C, 1'b0, 2'd1, 1'b0},
    {2'b11, 3'b101, 1'b1, 8'h5A, 1'b1, 2'd1, 1'b0}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic driveBit(input bit useLoop, input logic v);
    if (useLoop) loopLine = v;
    else         serialLine = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic sendFrame(input bit useLoop, input logic [1:0] wl, input logic [2:0] pctl,
                           input logic stp, input logic [7:0] dat, input logic flip,
                           input logic [1:0] bad, input logic brk);
    int n;
    int ns;
    logic [7:0] md;
    logic odd;
    n   = 5 + int'(wl);
    md  = dat & 8'((1 << n) - 1);
    odd = (pctl == 3'b001) || (pctl == 3'b010);
    driveBit(useLoop, 1'b0);
    for (int i = 0; i < n; i++) driveBit(useLoop, brk ? 1'b0 : md[i]);
    if (pctl[2:1] != 2'b11) driveBit(useLoop, brk ? 1'b0 : ((^md) ^ odd ^ flip));
    ns = (stp && wl != 2'b00) ? 2 : 1;
    for (int s = 0; s < ns; s++)
      driveBit(useLoop, (brk || bad == 2'(s + 1)) ? 1'b0 : 1'b1);
    driveBit(useLoop, 1'b1);
    driveBit(useLoop, 1'b1);
  endtask

  task automatic hostRead();
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!doneFlag) begin
      failCnt++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R8 reset state
    check("R8 reset dataReady", {7'd0, dataReady}, 8'd0);
    check("R8 reset flags", {3'd0, parityErr, framingErr, overrunErr, breakDet, 1'b0}, 8'd0);
    check("R2 reset data", rxData, 8'h00);
    rstN = 1'b1;
    repeat (8) @(negedge clk);

    for (int k = 0; k < 13; k++) begin
      logic [17:0] v;
      logic [7:0]  md;
      v = VECS[k];
      wordLenSel = v[17:16];
      parityCtl  = v[15:13];
      stopSel    = v[12];
      sendFrame(1'b0, v[17:16], v[15:13], v[12], v[11:4], v[3], v[2:1], v[0]);
      md = v[0] ? 8'h00 : (v[11:4] & 8'((1 << (5 + int'(v[17:16]))) - 1));
      check($sformatf("R2/R3 vec%0d dataReady", k), {7'd0, dataReady}, 8'd1);
      check($sformatf("R2 vec%0d data", k), rxData, md);
      check($sformatf("R4 vec%0d parity", k), {7'd0, parityErr},
            {7'd0, (!v[0] && v[3] && !v[15])});
      check($sformatf("R5 vec%0d framing", k), {7'd0, framingErr},
            {7'd0, (v[0] || v[2:1] != 2'd0)});
      check($sformatf("R6 vec%0d break", k), {7'd0, breakDet}, {7'd0, v[0]});
      hostRead();
      check($sformatf("R8 vec%0d cleared", k), {7'd0, dataReady}, 8'd0);
    end

    wordLenSel = 2'b11; parityCtl = 3'b000; stopSel = 1'b0;

    // R1 false start: a short low pulse
    serialLine = 1'b0;
    repeat (12) @(negedge clk);
    serialLine = 1'b1;
    repeat (4 * BIT_CLKS) @(negedge clk);
    check("R1 false start ignored", {7'd0, dataReady}, 8'd0);
    sendFrame(1'b0, 2'b11, 3'b000, 1'b0, 8'h96, 1'b0, 2'd0, 1'b0);
    check("R1 frame after glitch", rxData, 8'h96);
    check("R1 no error after glitch", {6'd0, parityErr, framingErr}, 8'd0);
    hostRead();

    // R7 overrun
    sendFrame(1'b0, 2'b11, 3'b000, 1'b0, 8'h11, 1'b0, 2'd0, 1'b0);
    sendFrame(1'b0, 2'b11, 3'b000, 1'b0, 8'h22, 1'b0, 2'd0, 1'b0);
    check("R7 overrun flag", {7'd0, overrunErr}, 8'd1);
    check("R7 data kept", rxData, 8'h11);
    check("R7 still ready", {7'd0, dataReady}, 8'd1);
    hostRead();
    check("R8 overrun cleared", {7'd0, overrunErr}, 8'd0);
    check("R8 ready cleared", {7'd0, dataReady}, 8'd0);

    // R9 receiver disabled
    rxEnable = 1'b0;
    sendFrame(1'b0, 2'b11, 3'b000, 1'b0, 8'h5C, 1'b0, 2'd0, 1'b0);
    check("R9 disabled no data", {7'd0, dataReady}, 8'd0);
    rxEnable = 1'b1;
    repeat (8) @(negedge clk);
    sendFrame(1'b0, 2'b11, 3'b000, 1'b0, 8'hE7, 1'b0, 2'd0, 1'b0);
    check("R9 reenabled data", rxData, 8'hE7);
    hostRead();

    // R10 loopback source
    loopSel = 1'b1;
    repeat (8) @(negedge clk);
    sendFrame(1'b0, 2'b11, 3'b000, 1'b0, 8'h33, 1'b0, 2'd0, 1'b0);
    check("R10 serialIn ignored", {7'd0, dataReady}, 8'd0);
    sendFrame(1'b1, 2'b11, 3'b000, 1'b0, 8'hC8, 1'b0, 2'd0, 1'b0);
    check("R10 loop ready", {7'd0, dataReady}, 8'd1);
    check("R10 loop data", rxData, 8'hC8);
    hostRead();
    loopSel = 1'b0;

    doneFlag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule